// File: doc/BRIEF.md
# Configuration Cycle Type Translator

This block sits at the upstream port of a bus bridge and watches the address phase of every configuration request that arrives from above. When the request is a Type 1 access aimed at the bus directly behind the bridge, it rewrites the address into a Type 0 access for the downstream bus. The rewrite turns the five-bit device number into a one-hot device-select pattern in the upper address half, clears the device field, marks the low two bits as Type 0, and passes the function and register fields through untouched.

Requests that do not qualify produce no output. This covers the wrong type bits, a bus number that differs from the programmed secondary bus number, and any command other than configuration read or write. Device number 31 is an escape: depending on the register field it either becomes a plain Type 0 access with no device selected or raises a special-cycle request. Translation only ever runs toward the downstream bus. The result is registered on the edge where the address-phase strobe is high and is presented for exactly one cycle.

Top module: `cfg_xlate`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `dn_ad` is zero and `xlate_valid` and `special_req` are low.
- R2: A request is considered only if `up_ad[1:0]` is 01b. Any other value gives no translation and no special request.
- R3: `up_ad[23:16]` must equal `sec_bus`. A mismatch gives no translation and no special request.
- R4: `up_cmd` must be 1010b (configuration read) or 1011b (configuration write). Any other command gives no output.
- R5: On any output, `dn_ad[1:0]` is 00b and `dn_ad[15:11]` is zero.
- R6: On any output, `dn_ad[10:2]` (function and register fields) equals `up_ad[10:2]`.
- R7: For device numbers 0 to 15 in `up_ad[15:11]`, `dn_ad[31:16]` has exactly one bit set, at bit 16 plus the device number, and `xlate_valid` is high.
- R8: For device numbers 16 to 30, `dn_ad[31:16]` is zero and `xlate_valid` is high.
- R9: For device number 31 with a nonzero register field `up_ad[7:2]`, `special_req` is high, `xlate_valid` is low and `dn_ad[31:16]` is zero.
- R10: For device number 31 with register field zero, `xlate_valid` is high, `special_req` is low and `dn_ad[31:16]` is zero.
- R11: Outputs change one clock after the edge on which `addr_strobe` is high and last one cycle. Without the strobe, all outputs are zero.
- R12: `xlate_valid` and `special_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_ad | input | 32 | Upstream address word during the address phase |
| up_cmd | input | 4 | Upstream bus command nibble |
| addr_strobe | input | 1 | High in the address-phase cycle |
| sec_bus | input | 8 | Programmed secondary bus number |
| dn_ad | output | 32 | Rewritten downstream address word |
| xlate_valid | output | 1 | Type 0 request issued downstream this cycle |
| special_req | output | 1 | Special-cycle request this cycle |

## Verification
The main tests are a sweep of all 32 device numbers and a table of single-fault requests. The sweep separates the one-hot range, the empty-select range and the device-31 escape, and it uses a register field tied to the device number so that pass-through errors show. Each table request is a legal one with exactly one condition broken: type bits 00b or 11b, a bus number off by one, or a memory command. This shows that every qualifier gates the output on its own. Further tests cover gaps between strobes, a second bus-number setting and a reset that arrives during a strobe, which check the one-cycle timing and the reset state.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
    localparam int ADDR_W   = 32;
    localparam int CMD_W    = 4;
    localparam int BUS_W    = 8;
    localparam int BUS_LSB  = 16;
    localparam int DEV_W    = 5;
    localparam int DEV_LSB  = 11;
    localparam int REG_W    = 6;
    localparam int REG_LSB  = 2;
    localparam int SEL_W    = 16;
    localparam int SEL_LSB  = 16;

    localparam logic [CMD_W-1:0] CMD_CFG_RD = 4'b1010;
    localparam logic [CMD_W-1:0] CMD_CFG_WR = 4'b1011;
    localparam logic [1:0]       KIND_T1    = 2'b01;
    localparam logic [1:0]       KIND_T0    = 2'b00;

    typedef struct packed {
        logic [ADDR_W-1:0] ad;
        logic              valid;
        logic              special;
    } xlate_out_t;
endpackage

// File: rtl/cfg_xlate_qualify.sv
module cfg_xlate_qualify
    import cfg_xlate_pkg::*;
(
    input  logic [1:0]       kind,
    input  logic [BUS_W-1:0] bus_num,
    input  logic [CMD_W-1:0] cmd,
    input  logic [BUS_W-1:0] sec_bus,
    output logic             hit
);
    logic kind_ok, bus_ok, cmd_ok;

    always_comb begin
        kind_ok = (kind == KIND_T1);
        bus_ok  = (bus_num == sec_bus);
        cmd_ok  = (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
        hit     = kind_ok && bus_ok && cmd_ok;
    end
endmodule

// File: rtl/cfg_xlate_idsel.sv
module cfg_xlate_idsel #(
    parameter int DW = 5,
    parameter int SW = 16
) (
    input  logic [DW-1:0] dev,
    output logic [SW-1:0] sel
);
    // One decoder per select line; device numbers at or above SW hit none.
    for (genvar i = 0; i < SW; i++) begin : g_line
        assign sel[i] = (dev == DW'(i));
    end
endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
    import cfg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] up_ad,
    input  logic [CMD_W-1:0]  up_cmd,
    input  logic              addr_strobe,
    input  logic [BUS_W-1:0]  sec_bus,
    output logic [ADDR_W-1:0] dn_ad,
    output logic              xlate_valid,
    output logic              special_req
);
    localparam int DEV_MSB = DEV_LSB + DEV_W - 1;
    localparam int REG_MSB = REG_LSB + REG_W - 1;
    localparam int SEL_MSB = SEL_LSB + SEL_W - 1;
    localparam int BUS_MSB = BUS_LSB + BUS_W - 1;
    localparam logic [DEV_W-1:0] DEV_ESC = '1;

    logic             hit;
    logic [SEL_W-1:0] sel;
    logic [DEV_W-1:0] dev;
    logic             escape;
    xlate_out_t       out_d, out_q;

    assign dev = up_ad[DEV_MSB:DEV_LSB];

    cfg_xlate_qualify u_qual (
        .kind    (up_ad[1:0]),
        .bus_num (up_ad[BUS_MSB:BUS_LSB]),
        .cmd     (up_cmd),
        .sec_bus (sec_bus),
        .hit     (hit)
    );

    cfg_xlate_idsel #(.DW(DEV_W), .SW(SEL_W)) u_sel (
        .dev (dev),
        .sel (sel)
    );

    always_comb begin
        out_d  = '0;
        escape = (dev == DEV_ESC) && (up_ad[REG_MSB:REG_LSB] != '0);
        if (addr_strobe && hit) begin
            out_d.ad                  = up_ad;
            out_d.ad[1:0]             = KIND_T0;
            out_d.ad[DEV_MSB:DEV_LSB] = '0;
            out_d.ad[SEL_MSB:SEL_LSB] = sel;
            out_d.valid               = !escape;
            out_d.special             = escape;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign dn_ad       = out_q.ad;
    assign xlate_valid = out_q.valid;
    assign special_req = out_q.special;

    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(xlate_valid && special_req));
    p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xlate_valid || special_req) |-> $onehot0(dn_ad[SEL_MSB:SEL_LSB]));
    p_fmt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xlate_valid || special_req) |-> (dn_ad[1:0] == KIND_T0 && dn_ad[DEV_MSB:DEV_LSB] == '0));
    p_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe && up_ad[1:0] != KIND_T1 |=> !xlate_valid && !special_req);
    p_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_strobe |=> !xlate_valid && !special_req && dn_ad == '0);
    p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |=> (xlate_valid || special_req) -> dn_ad[DEV_LSB-1:2] == $past(up_ad[DEV_LSB-1:2]));
endmodule

// File: tb/sim_cfg_xlate.sv
module sim_cfg_xlate;
    import cfg_xlate_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] ad;
        logic [3:0]  cmd;
        logic [31:0] exp_ad;
        logic        ev;
        logic        es;
    } vec_t;

    // secondary bus number is 8'h05 for all table rows
    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{32'h00051A41, 4'hA, 32'h00080240, 1'b1, 1'b0}, // R7 dev3 read
        '{32'h00051A41, 4'hB, 32'h00080240, 1'b1, 1'b0}, // R4 dev3 write
        '{32'h00051A40, 4'hA, 32'h00000000, 1'b0, 1'b0}, // R2 type 00
        '{32'h00051A43, 4'hA, 32'h00000000, 1'b0, 1'b0}, // R2 type 11
        '{32'h00061A41, 4'hA, 32'h00000000, 1'b0, 1'b0}, // R3 bus mismatch
        '{32'h00051A41, 4'h6, 32'h00000000, 1'b0, 1'b0}, // R4 memory command
        '{32'h0005FF01, 4'hA, 32'h00000700, 1'b1, 1'b0}, // R10 dev31 reg0
        '{32'h0005FFFD, 4'hB, 32'h000007FC, 1'b0, 1'b1}, // R9 dev31 special
        '{32'h0005A115, 4'hA, 32'h00000114, 1'b1, 1'b0}, // R8 dev20
        '{32'hFF057805, 4'hA, 32'h80000004, 1'b1, 1'b0}  // R7 dev15, upper bits dropped
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] up_ad = '0;
    logic [3:0]  up_cmd = '0;
    logic        addr_strobe = 1'b0;
    logic [7:0]  sec_bus = 8'h05;
    logic [31:0] dn_ad;
    logic        xlate_valid, special_req;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_xlate u0 (
        .clk(clk), .rst_n(rst_n), .up_ad(up_ad), .up_cmd(up_cmd),
        .addr_strobe(addr_strobe), .sec_bus(sec_bus),
        .dn_ad(dn_ad), .xlate_valid(xlate_valid), .special_req(special_req)
    );

    task automatic check(input string req, input logic [31:0] ea, input logic ev, input logic es);
        checks++;
        if (dn_ad !== ea || xlate_valid !== ev || special_req !== es) begin
            errors++;
            $display("FAIL %s: got ad=%h v=%b s=%b, expected ad=%h v=%b s=%b",
                     req, dn_ad, xlate_valid, special_req, ea, ev, es);
        end
    endtask

    // Drive one address phase, then sample the registered result mid-cycle.
    task automatic apply(input logic [31:0] ad, input logic [3:0] cmd, input string req,
                         input logic [31:0] ea, input logic ev, input logic es);
        @(negedge clk);
        up_ad = ad; up_cmd = cmd; addr_strobe = 1'b1;
        @(negedge clk);
        addr_strobe = 1'b0; up_ad = '0; up_cmd = '0;
        check(req, ea, ev, es);
    endtask

    function automatic logic [33:0] model(input logic [31:0] ad, input logic [3:0] cmd, input logic [7:0] bus);
        logic [31:0] r;
        logic [4:0]  dv;
        logic v, s;
        r = 32'h0; v = 1'b0; s = 1'b0;
        dv = ad[15:11];
        if (ad[1:0] == 2'b01 && ad[23:16] == bus && (cmd == 4'hA || cmd == 4'hB)) begin
            r[10:2] = ad[10:2];
            if (dv < 5'd16) r[16 + int'(dv)] = 1'b1;
            s = (dv == 5'd31) && (ad[7:2] != 6'd0);
            v = !s;
        end
        return {r, v, s};
    endfunction

    initial begin
        logic [33:0] e;
        logic [31:0] a;
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1 in reset", 32'h0, 1'b0, 1'b0);
        up_ad = 32'h00051A41; up_cmd = 4'hA; addr_strobe = 1'b1;
        @(negedge clk);
        check("R1 strobe ignored in reset", 32'h0, 1'b0, 1'b0);
        addr_strobe = 1'b0; up_ad = '0; up_cmd = '0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 32'h0, 1'b0, 1'b0);

        for (int i = 0; i < NVEC; i++)
            apply(VECS[i].ad, VECS[i].cmd, $sformatf("table row %0d", i),
                  VECS[i].exp_ad, VECS[i].ev, VECS[i].es);

        // R7 R8 R9 R10 R6: sweep every device number
        for (int d = 0; d < 32; d++) begin
            a = {8'h00, 8'h05, 5'(d), 3'(d), 6'(d), 2'b01};
            e = model(a, 4'hB, 8'h05);
            apply(a, 4'hB, $sformatf("R7/R8/R9 sweep dev %0d", d), e[33:2], e[1], e[0]);
        end
        // R9: device 31 special with minimal nonzero register field
        apply(32'h0005F805, 4'hA, "R9 dev31 reg1", 32'h00000004, 1'b0, 1'b1);

        // R11: held one cycle, then zero
        apply(32'h00052341, 4'hA, "R11 capture dev4", 32'h00100340, 1'b1, 1'b0);
        @(negedge clk);
        check("R11 no strobe zero", 32'h0, 1'b0, 1'b0);
        up_ad = 32'h00052341; up_cmd = 4'hA;
        @(negedge clk);
        check("R11 valid inputs without strobe", 32'h0, 1'b0, 1'b0);
        up_ad = '0; up_cmd = '0;

        // R3: another bus number
        sec_bus = 8'hFF;
        apply(32'h00FF0841, 4'hA, "R3 bus FF match", 32'h00020040, 1'b1, 1'b0);
        apply(32'h00050841, 4'hA, "R3 bus FF mismatch", 32'h0, 1'b0, 1'b0);
        sec_bus = 8'h05;

        // R1: reset during a strobe
        apply(32'h00051A41, 4'hA, "R7 before reset", 32'h00080240, 1'b1, 1'b0);
        @(negedge clk);
        up_ad = 32'h00051A41; up_cmd = 4'hA; addr_strobe = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset wins over strobe", 32'h0, 1'b0, 1'b0);
        addr_strobe = 1'b0; rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got running, expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule